// File: doc/BRIEF.md
# Modem Control and Status Logic

This block is the modem-side register pair of one serial channel. A host writes a control byte that drives the request-to-send, data-terminal-ready and two auxiliary outputs. The same byte can place the channel in a loopback mode. A status byte reports the present level of the four incoming modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The status byte also has four sticky change flags. These flags record activity since the host last read the status byte, and reading the status byte clears them.

The incoming lines are synchronised before use. A modem-status interrupt request is raised while any change flag is set and its enable bit is on. In loopback mode the control outputs are routed internally onto the status inputs, the external modem outputs are held inactive, and the serial data output is held at mark. This allows the host to test the channel without a modem attached. All signals are active high at this boundary.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control byte, the enable byte, all four change flags, the interrupt request and the four modem outputs are 0.
- R2: A control write stores bits 0..4 (0 = DTR, 1 = RTS, 2 = AUX1, 3 = AUX2, 4 = LOOP). Bits 5..7 always read 0. Outside loopback, dtr_out, rts_out, aux1_out and aux2_out follow bits 0..3.
- R3: An enable write stores bits 0..3, and bits 4..7 always read 0. Bit 3 is the modem-status interrupt enable.
- R4: Status bits 4..7 show the current CTS, DSR, RI and DCD levels. An external line change becomes visible SYNC_STAGES clock edges after it is applied.
- R5: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) set on any change of the corresponding current level.
- R6: Status bit 2 sets only when the current RI level falls from 1 to 0. A rise of RI leaves it unchanged.
- R7: A one-cycle pulse on rd_msr clears all change flags. A change that happens on the same edge as the clear wins, and its flag stays set.
- R8: irq is high exactly when enable bit 3 is set and at least one change flag is set.
- R9: In loopback mode RTS, DTR, AUX1 and AUX2 become the current CTS, DSR, RI and DCD levels. The external modem inputs are ignored, and the four modem outputs are 0.
- R10: In loopback mode sout is 1. Otherwise sout equals sout_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mcr | input | 1 | Write strobe for the control byte |
| wr_ier | input | 1 | Write strobe for the enable byte |
| wdata | input | 8 | Write data |
| rd_msr | input | 1 | Status read strobe; clears the change flags |
| mcr_rdata | output | 8 | Control byte readback |
| ier_rdata | output | 8 | Enable byte readback |
| msr_rdata | output | 8 | Status byte |
| cts_in | input | 1 | Clear-to-send from the modem |
| dsr_in | input | 1 | Data-set-ready from the modem |
| ri_in | input | 1 | Ring indicator from the modem |
| dcd_in | input | 1 | Carrier detect from the modem |
| rts_out | output | 1 | Request-to-send to the modem |
| dtr_out | output | 1 | Data-terminal-ready to the modem |
| aux1_out | output | 1 | Auxiliary output 1 |
| aux2_out | output | 1 | Auxiliary output 2 |
| sout_in | input | 1 | Serial data from the transmitter |
| sout | output | 1 | Serial data to the line |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES = 2 and the falling-edge RI variant. These values keep the input latency at two edges, so the bench can probe exactly the cycle in which a status change appears. With that latency it can also line up a read strobe with the edge that sets a change flag. With only four modem lines, the bench sweeps every ordered pair of input patterns, every control byte and every enable byte. Each expected flag value is the XOR or the falling-edge term of the two patterns.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int NLINES   = 4;
   localparam int LN_CTS   = 0;
   localparam int LN_DSR   = 1;
   localparam int LN_RI    = 2;
   localparam int LN_DCD   = 3;
   localparam int CB_DTR   = 0;
   localparam int CB_RTS   = 1;
   localparam int CB_AUX1  = 2;
   localparam int CB_AUX2  = 3;
   localparam int CB_LOOP  = 4;
   localparam logic [7:0] CTRL_MASK = 8'h1F;
   localparam logic [7:0] EN_MASK   = 8'h0F;
   localparam int EN_MODEM = 3;
   typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= '0;
            else if (s == 0)
               chain[s] <= d;
            else
               chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter bit FALL_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic clr,
   output logic flag
);
   logic prev_q;
   logic chg;

   generate
      if (FALL_ONLY) begin : g_fall
         assign chg = prev_q & ~cur;
      end else begin : g_any
         assign chg = prev_q ^ cur;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag   <= 1'b0;
      end else begin
         prev_q <= cur;
         if (chg)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit RI_TRAIL_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_mcr,
   input  logic       wr_ier,
   input  logic [7:0] wdata,
   input  logic       rd_msr,
   output logic [7:0] mcr_rdata,
   output logic [7:0] ier_rdata,
   output logic [7:0] msr_rdata,
   input  logic       cts_in,
   input  logic       dsr_in,
   input  logic       ri_in,
   input  logic       dcd_in,
   output logic       rts_out,
   output logic       dtr_out,
   output logic       aux1_out,
   output logic       aux2_out,
   input  logic       sout_in,
   output logic       sout,
   output logic       irq
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("modem_ctl_stat: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [7:0] ctrl_q;
   logic [7:0] en_q;
   line_vec_t  ext_raw, ext_sync, loop_vec, cur_vec, flags;
   logic       loop_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else begin
         if (wr_mcr) ctrl_q <= wdata & CTRL_MASK;
         if (wr_ier) en_q   <= wdata & EN_MASK;
      end
   end

   assign loop_on = ctrl_q[CB_LOOP];

   assign ext_raw[LN_CTS] = cts_in;
   assign ext_raw[LN_DSR] = dsr_in;
   assign ext_raw[LN_RI]  = ri_in;
   assign ext_raw[LN_DCD] = dcd_in;

   mdm_sync #(.STAGES(SYNC_STAGES), .W(NLINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_raw),
      .q     (ext_sync)
   );

   assign loop_vec[LN_CTS] = ctrl_q[CB_RTS];
   assign loop_vec[LN_DSR] = ctrl_q[CB_DTR];
   assign loop_vec[LN_RI]  = ctrl_q[CB_AUX1];
   assign loop_vec[LN_DCD] = ctrl_q[CB_AUX2];

   assign cur_vec = loop_on ? loop_vec : ext_sync;

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         mdm_delta #(.FALL_ONLY((i == LN_RI) && RI_TRAIL_ONLY)) u_delta (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur_vec[i]),
            .clr   (rd_msr),
            .flag  (flags[i])
         );
      end
   endgenerate

   assign mcr_rdata = ctrl_q;
   assign ier_rdata = en_q;
   assign msr_rdata = {cur_vec, flags};

   assign dtr_out  = ctrl_q[CB_DTR]  & ~loop_on;
   assign rts_out  = ctrl_q[CB_RTS]  & ~loop_on;
   assign aux1_out = ctrl_q[CB_AUX1] & ~loop_on;
   assign aux2_out = ctrl_q[CB_AUX2] & ~loop_on;
   assign sout     = loop_on | sout_in;
   assign irq      = en_q[EN_MODEM] & (|flags);
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_msr,
   input logic [7:0] mcr_rdata,
   input logic [7:0] ier_rdata,
   input logic [7:0] msr_rdata,
   input logic       rts_out,
   input logic       dtr_out,
   input logic       aux1_out,
   input logic       aux2_out,
   input logic       sout,
   input logic       irq
);
   // R2
   ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcr_rdata[7:5] == 3'b000);

   // R3
   en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ier_rdata[7:4] == 4'b0000);

   // R6
   ri_trail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msr_rdata[2]) |-> (!$past(msr_rdata[6]) && $past(msr_rdata[6], 2)));

   // R7
   flag_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|msr_rdata[3:0]) |-> $past(rd_msr));

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ier_rdata[3] && (|msr_rdata[3:0])));

   // R8
   irq_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_rdata[3] && (|msr_rdata[3:0])) |-> irq);

   // R9
   loop_outputs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcr_rdata[4] |-> !(rts_out || dtr_out || aux1_out || aux2_out));

   // R9
   loop_cts_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcr_rdata[4] |-> (msr_rdata[4] == mcr_rdata[1]));

   // R10
   loop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcr_rdata[4] |-> sout);
endmodule

bind modem_ctl_stat mdm_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_msr    (rd_msr),
   .mcr_rdata (mcr_rdata),
   .ier_rdata (ier_rdata),
   .msr_rdata (msr_rdata),
   .rts_out   (rts_out),
   .dtr_out   (dtr_out),
   .aux1_out  (aux1_out),
   .aux2_out  (aux2_out),
   .sout      (sout),
   .irq       (irq)
);

// File: tb/modem_ctl_stat_test.sv
module modem_ctl_stat_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_mcr = 1'b0, wr_ier = 1'b0, rd_msr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] mcr_rdata, ier_rdata, msr_rdata;
   logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
   logic       rts_out, dtr_out, aux1_out, aux2_out;
   logic       sout_in = 1'b0, sout, irq;
   int         n_tests = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   modem_ctl_stat #(.SYNC_STAGES(2), .RI_TRAIL_ONLY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_mcr(wr_mcr), .wr_ier(wr_ier), .wdata(wdata),
      .rd_msr(rd_msr), .mcr_rdata(mcr_rdata), .ier_rdata(ier_rdata),
      .msr_rdata(msr_rdata), .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in),
      .dcd_in(dcd_in), .rts_out(rts_out), .dtr_out(dtr_out), .aux1_out(aux1_out),
      .aux2_out(aux2_out), .sout_in(sout_in), .sout(sout), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      wdata = v; wr_mcr = 1'b1; @(negedge clk); wr_mcr = 1'b0;
   endtask

   task automatic wr_en(input logic [7:0] v);
      wdata = v; wr_ier = 1'b1; @(negedge clk); wr_ier = 1'b0;
   endtask

   task automatic rd_pulse();
      rd_msr = 1'b1; @(negedge clk); rd_msr = 1'b0;
   endtask

   task automatic set_in(input logic [3:0] v);
      cts_in = v[0]; dsr_in = v[1]; ri_in = v[2]; dcd_in = v[3];
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset state
      chk("R1", {mcr_rdata, ier_rdata, msr_rdata}, 24'h0);
      chk("R1", {irq, rts_out, dtr_out, aux1_out, aux2_out}, 5'b0);
      rst_n = 1'b1;
      idle(2);
      chk("R1", {msr_rdata[3:0], irq}, 5'b0);

      // R2 R3 R10 sweep of every control and enable byte
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = v[7:0];
         sout_in = b[5];
         wr_ctrl(b);
         chk("R2", mcr_rdata, b & 8'h1F);
         chk("R2", {dtr_out, rts_out, aux1_out, aux2_out},
             b[4] ? 4'b0 : {b[0], b[1], b[2], b[3]});
         chk("R10", sout, b[4] ? 1'b1 : b[5]);
         wr_en(b);
         chk("R3", ier_rdata, b & 8'h0F);
      end
      wr_ctrl(8'h00);
      wr_en(8'h08);
      idle(4);
      rd_pulse();

      // R5 R6 R7 R8 all ordered input pattern pairs
      for (int a = 0; a < 16; a++) begin
         for (int c = 0; c < 16; c++) begin
            logic [3:0] pa, pb, ed;
            pa = a[3:0]; pb = c[3:0];
            ed = {pa[3] ^ pb[3], pa[2] & ~pb[2], pa[1] ^ pb[1], pa[0] ^ pb[0]};
            set_in(pa); idle(4); rd_pulse();
            set_in(pb); idle(4);
            chk("R4", msr_rdata[7:4], pb);
            chk("R5_R6", msr_rdata[3:0], ed);
            chk("R8", irq, |ed);
            rd_pulse();
            chk("R7", {msr_rdata[3:0], irq}, 5'b0);
         end
      end

      // R8 enable off masks a pending flag
      set_in(4'h0); idle(4); rd_pulse();
      set_in(4'h1); idle(4);
      wr_en(8'h00);
      chk("R8", irq, 1'b0);
      chk("R8", msr_rdata[0], 1'b1);
      wr_en(8'h08);
      chk("R8", irq, 1'b1);
      rd_pulse();

      // R4 latency and R7 set-wins-over-clear
      set_in(4'h0); idle(4); rd_pulse();
      cts_in = 1'b1;
      idle(1);
      chk("R4", msr_rdata[4], 1'b0);
      idle(1);
      chk("R4", msr_rdata[4], 1'b1);
      chk("R7", msr_rdata[0], 1'b0);
      rd_pulse();
      chk("R7", msr_rdata[0], 1'b1);
      rd_pulse();
      chk("R7", msr_rdata[0], 1'b0);

      // R9 loopback routing and external inputs ignored
      for (int m = 0; m < 16; m++) begin
         logic [3:0] mv;
         mv = m[3:0];
         set_in(~mv); idle(4);
         wr_ctrl({4'b0001, mv});
         idle(2); rd_pulse();
         chk("R9", msr_rdata[7:4], {mv[3], mv[2], mv[0], mv[1]});
         set_in(mv); idle(4);
         chk("R9", msr_rdata, {mv[3], mv[2], mv[0], mv[1], 4'b0});
         chk("R9", {rts_out, dtr_out, aux1_out, aux2_out}, 4'b0);
         chk("R10", sout, 1'b1);
      end
      wr_ctrl(8'h00);
      idle(4); rd_pulse();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule